// File: doc/BRIEF.md
# Synchronized Frequency Hop Controller

This block commits new oscillator tuning words into several channels at a known clock edge. Each channel holds a 32-bit staging register that software fills in two 16-bit halves, and a 32-bit live register that feeds the oscillator. A channel also holds a 16-bit delay value. The staging register only moves into the live register when a countdown of that delay expires, so software can stage the new words at any time.

A countdown starts in one of two ways. A command strobe carries a hop flag and a channel mask, and it arms every selected channel in the same cycle. A rising edge on an external sync pin arms every channel set in a separate pin mask. Either trigger passes through a fixed seven-stage delay before it loads the channel counter. The live register therefore changes exactly delay + 7 clock edges after the trigger edge. No channel has to be idled first. A one-cycle done flag marks each commit.

Top module: `hop_sync_ctrl`

## Requirements
- R1: After reset every live register reads 0, every done flag is low, every staging register holds 0 and every delay value is 1.
- R2: A config write with select 0 loads staging bits [15:0] of channel `cfg_ch` from `cfg_data`, and select 1 loads bits [31:16]. A staging write never changes a live register by itself.
- R3: A config write with select 2 loads the channel delay from `cfg_data`. A write of 0 with select 2 is ignored and the previous delay stays. A write with select 3 changes nothing.
- R4: A command strobe with the hop flag set arms every channel whose bit is set in `cmd_mask`. A strobe with the hop flag clear arms nothing.
- R5: When a channel is armed at clock edge E with delay H (1 to 65535), its live register takes the staging value at edge E + H + 7 and not before.
- R6: The done flag of a channel is high for exactly the one cycle that follows the edge at which its live register is loaded, once per commit.
- R7: Arming a channel again while its countdown runs restarts the count, so the commit happens H + 7 edges after the latest trigger and happens only once.
- R8: Staging writes made during a countdown are the ones committed: the live register takes the staging value held just before the commit edge.
- R9: A rising edge of `sync_pin` (low at the previous edge, high at this one) arms every channel set in `pin_mask` with the same timing as R5. Holding the pin high does not re-arm.
- R10: Channels are independent: each uses its own delay, and a channel that is not armed keeps its live register and raises no done flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Config write strobe |
| cfg_ch | input | CH_W | Channel addressed by the write |
| cfg_sel | input | 2 | Target: 0 staging low half, 1 staging high half, 2 delay, 3 none |
| cfg_data | input | HALF_W | Write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_hop | input | 1 | Hop flag of the command |
| cmd_mask | input | NUM_CH | Channels selected by the command |
| sync_pin | input | 1 | External sync input, rising edge active |
| pin_mask | input | NUM_CH | Channels that respond to the sync pin |
| work_freq | output | NUM_CH*2*HALF_W | Live tuning words, channel 0 in the low bits |
| hop_done | output | NUM_CH | One-cycle commit flag per channel |

## Verification
The bench builds the block with three channels, 16-bit halves, 16-bit delays and the default seven-stage trigger delay. With three channels every non-empty command mask can be swept against eight delay settings, and each channel gets a different delay. This covers every combination of armed and idle channels at distinct commit times. The narrow channel count leaves room in the run for the largest delay, 65535, so the top of the counter range and the exact delay + 7 timing are measured directly.

// File: rtl/hop_sync_pkg.sv
package hop_sync_pkg;

    typedef enum logic [1:0] {
        SEL_FREQ_LO = 2'd0,
        SEL_FREQ_HI = 2'd1,
        SEL_HOLD    = 2'd2,
        SEL_NONE    = 2'd3
    } cfg_sel_e;

endpackage

// File: rtl/hop_sync_trig.sv
// Trigger front end: pin edge detect, command/pin merge, fixed delay pipe.
module hop_sync_trig #(
    parameter int NUM_CH   = 4,
    parameter int TRIG_LAT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_hop,
    input  logic [NUM_CH-1:0] cmd_mask,
    input  logic              sync_pin,
    input  logic [NUM_CH-1:0] pin_mask,
    output logic [NUM_CH-1:0] load_mask
);

    typedef struct packed {
        logic                             pin;
        logic [TRIG_LAT-1:0][NUM_CH-1:0]  pipe;
    } trig_st_t;

    trig_st_t          st_d, st_q;
    logic              pin_rise;
    logic [NUM_CH-1:0] arm_now;

    always_comb begin
        st_d     = st_q;
        pin_rise = sync_pin & ~st_q.pin;
        arm_now  = ({NUM_CH{cmd_valid & cmd_hop}} & cmd_mask)
                 | ({NUM_CH{pin_rise}} & pin_mask);
        st_d.pin     = sync_pin;
        st_d.pipe[0] = arm_now;
        for (int k = 1; k < TRIG_LAT; k++) begin
            st_d.pipe[k] = st_q.pipe[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_mask = st_q.pipe[TRIG_LAT-1];

endmodule

// File: rtl/hop_sync_chan.sv
// One channel: staging word, delay value, countdown and live word.
module hop_sync_chan
    import hop_sync_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int HOLD_W = 16,
    localparam int FREQ_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  cfg_sel_e          wr_sel,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              load,
    output logic [FREQ_W-1:0] work,
    output logic              done
);

    typedef struct packed {
        logic [FREQ_W-1:0] shadow;
        logic [HOLD_W-1:0] hold;
        logic [HOLD_W-1:0] cnt;
        logic [FREQ_W-1:0] work;
        logic              done;
    } chan_st_t;

    chan_st_t          st_d, st_q;
    logic [HOLD_W-1:0] wr_hold;

    assign wr_hold = wr_data[HOLD_W-1:0];

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;

        if (wr_en) begin
            unique case (wr_sel)
                SEL_FREQ_LO: st_d.shadow[HALF_W-1:0]      = wr_data;
                SEL_FREQ_HI: st_d.shadow[FREQ_W-1:HALF_W] = wr_data;
                SEL_HOLD: begin
                    if (wr_hold != '0) begin
                        st_d.hold = wr_hold;
                    end
                end
                default: ;
            endcase
        end

        // cnt == 0 means idle; expiry is the edge at which cnt is 1
        if (st_q.cnt == HOLD_W'(1)) begin
            st_d.work = st_q.shadow;
            st_d.done = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - HOLD_W'(1);
        end

        if (load) begin
            st_d.cnt = st_q.hold;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.hold <= HOLD_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign work = st_q.work;
    assign done = st_q.done;

endmodule

// File: rtl/hop_sync_ctrl.sv
module hop_sync_ctrl
    import hop_sync_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int HALF_W   = 16,
    parameter int HOLD_W   = 16,
    parameter int TRIG_LAT = 7,
    localparam int FREQ_W  = 2 * HALF_W,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [CH_W-1:0]          cfg_ch,
    input  logic [1:0]               cfg_sel,
    input  logic [HALF_W-1:0]        cfg_data,
    input  logic                     cmd_valid,
    input  logic                     cmd_hop,
    input  logic [NUM_CH-1:0]        cmd_mask,
    input  logic                     sync_pin,
    input  logic [NUM_CH-1:0]        pin_mask,
    output logic [NUM_CH*FREQ_W-1:0] work_freq,
    output logic [NUM_CH-1:0]        hop_done
);

    logic [NUM_CH-1:0] load_mask;
    cfg_sel_e          sel;

    assign sel = cfg_sel_e'(cfg_sel);

    hop_sync_trig #(
        .NUM_CH   (NUM_CH),
        .TRIG_LAT (TRIG_LAT)
    ) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_hop   (cmd_hop),
        .cmd_mask  (cmd_mask),
        .sync_pin  (sync_pin),
        .pin_mask  (pin_mask),
        .load_mask (load_mask)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        logic wr_hit;
        assign wr_hit = cfg_we && (cfg_ch == CH_W'(i));

        hop_sync_chan #(
            .HALF_W (HALF_W),
            .HOLD_W (HOLD_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_hit),
            .wr_sel  (sel),
            .wr_data (cfg_data),
            .load    (load_mask[i]),
            .work    (work_freq[i*FREQ_W +: FREQ_W]),
            .done    (hop_done[i])
        );
    end

endmodule

// File: rtl/hop_sync_ctrl_chk.sv
module hop_sync_ctrl_chk #(
    parameter int NUM_CH   = 4,
    parameter int HALF_W   = 16,
    parameter int TRIG_LAT = 7,
    localparam int FREQ_W  = 2 * HALF_W
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cmd_valid,
    input logic                     cmd_hop,
    input logic [NUM_CH-1:0]        cmd_mask,
    input logic                     sync_pin,
    input logic [NUM_CH-1:0]        pin_mask,
    input logic [NUM_CH*FREQ_W-1:0] work_freq,
    input logic [NUM_CH-1:0]        hop_done
);

    logic                            pin_prev;
    logic [NUM_CH-1:0]               arm;
    logic [TRIG_LAT-1:0][NUM_CH-1:0] aged;

    assign arm = ({NUM_CH{cmd_valid & cmd_hop}} & cmd_mask)
               | ({NUM_CH{sync_pin & ~pin_prev}} & pin_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_prev <= 1'b0;
            aged     <= '0;
        end else begin
            pin_prev <= sync_pin;
            aged[0]  <= arm;
            for (int k = 1; k < TRIG_LAT; k++) begin
                aged[k] <= aged[k-1];
            end
        end
    end

    AST_RESET_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (hop_done == '0)); // R1
    AST_RESET_WORK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (work_freq == '0)); // R1

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // triggers older than the fixed delay that have not yet been matched by a commit
        logic [15:0] credit;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                credit <= '0;
            end else if (aged[TRIG_LAT-1][i] && !hop_done[i]) begin
                credit <= credit + 16'd1;
            end else if (!aged[TRIG_LAT-1][i] && hop_done[i] && credit != '0) begin
                credit <= credit - 16'd1;
            end
        end

        AST_DONE_NEEDS_AGED_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
            hop_done[i] |-> (credit != 16'd0)); // R5
        AST_WORK_ONLY_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(work_freq[i*FREQ_W +: FREQ_W]) |-> hop_done[i]); // R2
    end

endmodule

bind hop_sync_ctrl hop_sync_ctrl_chk #(
    .NUM_CH   (NUM_CH),
    .HALF_W   (HALF_W),
    .TRIG_LAT (TRIG_LAT)
) u_chk (.*);

// File: tb/hop_sync_ctrl_bench.sv
`timescale 1ns/1ps
module hop_sync_ctrl_bench;

    localparam int NUM_CH   = 3;
    localparam int HALF_W   = 16;
    localparam int HOLD_W   = 16;
    localparam int TRIG_LAT = 7;
    localparam int FREQ_W   = 32;
    localparam int CH_W     = 2;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     cfg_we = 1'b0;
    logic [CH_W-1:0]          cfg_ch = '0;
    logic [1:0]               cfg_sel = '0;
    logic [HALF_W-1:0]        cfg_data = '0;
    logic                     cmd_valid = 1'b0;
    logic                     cmd_hop = 1'b0;
    logic [NUM_CH-1:0]        cmd_mask = '0;
    logic                     sync_pin = 1'b0;
    logic [NUM_CH-1:0]        pin_mask = '0;
    logic [NUM_CH*FREQ_W-1:0] work_freq;
    logic [NUM_CH-1:0]        hop_done;

    always #2.5 clk = ~clk;

    hop_sync_ctrl #(
        .NUM_CH   (NUM_CH),
        .HALF_W   (HALF_W),
        .HOLD_W   (HOLD_W),
        .TRIG_LAT (TRIG_LAT)
    ) u_hop_sync_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_ch    (cfg_ch),
        .cfg_sel   (cfg_sel),
        .cfg_data  (cfg_data),
        .cmd_valid (cmd_valid),
        .cmd_hop   (cmd_hop),
        .cmd_mask  (cmd_mask),
        .sync_pin  (sync_pin),
        .pin_mask  (pin_mask),
        .work_freq (work_freq),
        .hop_done  (hop_done)
    );

    // requirement-level model, driven only by the bench's own stimulus
    longint            cyc = 0;
    longint            due [NUM_CH];
    longint            last_trig [NUM_CH];
    longint            last_done [NUM_CH];
    int                done_cnt [NUM_CH];
    logic [FREQ_W-1:0] shadow_m [NUM_CH];
    logic [FREQ_W-1:0] work_m [NUM_CH];
    logic [HOLD_W-1:0] hold_m [NUM_CH];
    logic              pin_prev = 1'b0;
    int                total = 0;
    int                bad = 0;

    initial begin
        for (int c = 0; c < NUM_CH; c++) begin
            due[c] = -1; last_trig[c] = 0; last_done[c] = 0; done_cnt[c] = 0;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                shadow_m[c] <= '0;
                work_m[c]   <= '0;
                hold_m[c]   <= HOLD_W'(1);
                due[c]      <= -1;
            end
            pin_prev <= 1'b0;
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (due[c] == cyc) work_m[c] <= shadow_m[c];
                if ((cmd_valid && cmd_hop && cmd_mask[c]) ||
                    (sync_pin && !pin_prev && pin_mask[c])) begin
                    due[c]       <= cyc + longint'(hold_m[c]) + TRIG_LAT;
                    last_trig[c] <= cyc;
                end
                if (cfg_we && int'(cfg_ch) == c) begin
                    case (cfg_sel)
                        2'd0: shadow_m[c][15:0]  <= cfg_data;
                        2'd1: shadow_m[c][31:16] <= cfg_data;
                        2'd2: if (cfg_data != '0) hold_m[c] <= cfg_data;
                        default: ;
                    endcase
                end
            end
            pin_prev <= sync_pin;
        end
        cyc <= cyc + 1;
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // every cycle: done flag (R6) and live word (R5) against the model
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                chk("R6", $sformatf("done ch%0d cyc%0d", c, cyc - 1),
                    64'(hop_done[c]), 64'(due[c] == cyc - 1));
                chk("R5", $sformatf("work ch%0d cyc%0d", c, cyc - 1),
                    64'(work_freq[c*FREQ_W +: FREQ_W]), 64'(work_m[c]));
                if (hop_done[c]) begin
                    done_cnt[c]++;
                    last_done[c] = cyc - 1;
                end
            end
        end
    end

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input int ch, input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = CH_W'(ch); cfg_sel = sel; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_freq(input int ch, input logic [31:0] v);
        wr(ch, 2'd0, v[15:0]);
        wr(ch, 2'd1, v[31:16]);
    endtask

    task automatic hop(input logic [NUM_CH-1:0] m, input logic hb);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_hop = hb; cmd_mask = m;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_hop = 1'b0; cmd_mask = '0;
    endtask

    function automatic logic [31:0] work_of(input int ch);
        return work_freq[ch*FREQ_W +: FREQ_W];
    endfunction

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        int snap [NUM_CH];
        logic [31:0] wsnap [NUM_CH];

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        settle(1);

        // R1: reset state, and the reset delay of 1 gives 1 + 7
        for (int c = 0; c < NUM_CH; c++) begin
            chk("R1", $sformatf("reset work ch%0d", c), 64'(work_of(c)), 64'd0);
            chk("R1", $sformatf("reset done ch%0d", c), 64'(hop_done[c]), 64'd0);
        end
        hop(3'b001, 1'b1);
        settle(12);
        chk("R1", "reset delay latency", 64'(last_done[0] - last_trig[0]), 64'd8);
        chk("R1", "reset staging is zero", 64'(work_of(0)), 64'd0);

        // R2: halves placement and no effect before a hop
        set_freq(1, 32'hA5A5_1234);
        settle(3);
        chk("R2", "staging write leaves live word", 64'(work_of(1)), 64'd0);
        hop(3'b010, 1'b1);
        settle(12);
        chk("R2", "halves placement", 64'(work_of(1)), 64'hA5A5_1234);

        // R3: delay load, zero ignored, select 3 ignored
        wr(0, 2'd2, 16'd5);
        wr(0, 2'd2, 16'd0);
        set_freq(0, 32'h1111_2222);
        hop(3'b001, 1'b1);
        settle(15);
        chk("R3", "zero delay write ignored", 64'(last_done[0] - last_trig[0]), 64'd12);
        chk("R3", "commit value", 64'(work_of(0)), 64'h1111_2222);
        wr(0, 2'd3, 16'h7777);
        snap[0] = done_cnt[0];
        hop(3'b001, 1'b1);
        settle(15);
        chk("R3", "select 3 leaves staging", 64'(work_of(0)), 64'h1111_2222);
        chk("R3", "select 3 leaves delay", 64'(last_done[0] - last_trig[0]), 64'd12);

        // R4: hop flag clear arms nothing
        for (int c = 0; c < NUM_CH; c++) begin
            set_freq(c, 32'hDEAD_0000 | 32'(c));
            snap[c] = done_cnt[c]; wsnap[c] = work_of(c);
        end
        hop(3'b111, 1'b0);
        settle(25);
        for (int c = 0; c < NUM_CH; c++) begin
            chk("R4", $sformatf("no done ch%0d", c), 64'(done_cnt[c] - snap[c]), 64'd0);
            chk("R4", $sformatf("no commit ch%0d", c), 64'(work_of(c)), 64'(wsnap[c]));
        end

        // R5, R6, R10: every mask against several delays
        for (int h = 1; h <= 8; h++) begin
            for (int m = 1; m < (1 << NUM_CH); m++) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    wr(c, 2'd2, 16'(h + 3 * c));
                    set_freq(c, {8'(h), 8'(m), 16'(c + 256)});
                    snap[c] = done_cnt[c]; wsnap[c] = work_of(c);
                end
                hop(NUM_CH'(m), 1'b1);
                settle(h + 6 + TRIG_LAT + 3);
                for (int c = 0; c < NUM_CH; c++) begin
                    if (m[c]) begin
                        chk("R5", $sformatf("latency h%0d m%0d ch%0d", h, m, c),
                            64'(last_done[c] - last_trig[c]), 64'(h + 3 * c + TRIG_LAT));
                        chk("R6", $sformatf("one pulse h%0d m%0d ch%0d", h, m, c),
                            64'(done_cnt[c] - snap[c]), 64'd1);
                        chk("R5", $sformatf("value h%0d m%0d ch%0d", h, m, c),
                            64'(work_of(c)), 64'({8'(h), 8'(m), 16'(c + 256)}));
                    end else begin
                        chk("R10", $sformatf("idle done h%0d m%0d ch%0d", h, m, c),
                            64'(done_cnt[c] - snap[c]), 64'd0);
                        chk("R10", $sformatf("idle work h%0d m%0d ch%0d", h, m, c),
                            64'(work_of(c)), 64'(wsnap[c]));
                    end
                end
            end
        end

        // R7: retrigger restarts the count
        wr(1, 2'd2, 16'd20);
        set_freq(1, 32'h0BAD_F00D);
        snap[1] = done_cnt[1];
        hop(3'b010, 1'b1);
        settle(5);
        hop(3'b010, 1'b1);
        settle(32);
        chk("R7", "latency from latest trigger", 64'(last_done[1] - last_trig[1]), 64'd27);
        chk("R7", "single commit", 64'(done_cnt[1] - snap[1]), 64'd1);

        // R8: staging rewritten during the countdown
        wr(2, 2'd2, 16'd15);
        set_freq(2, 32'h0000_AAAA);
        snap[2] = done_cnt[2];
        hop(3'b100, 1'b1);
        settle(2);
        set_freq(2, 32'h5555_BBBB);
        settle(22);
        chk("R8", "latest staging committed", 64'(work_of(2)), 64'h5555_BBBB);
        chk("R8", "single commit", 64'(done_cnt[2] - snap[2]), 64'd1);

        // R9: pin rising edge, held high, then a second edge
        wr(0, 2'd2, 16'd4);
        wr(2, 2'd2, 16'd9);
        for (int c = 0; c < NUM_CH; c++) begin
            set_freq(c, 32'hC0DE_0000 | 32'(c));
            snap[c] = done_cnt[c];
        end
        pin_mask = 3'b101;
        @(negedge clk);
        sync_pin = 1'b1;
        settle(40);
        chk("R9", "ch0 one commit", 64'(done_cnt[0] - snap[0]), 64'd1);
        chk("R9", "ch2 one commit", 64'(done_cnt[2] - snap[2]), 64'd1);
        chk("R9", "ch1 not armed", 64'(done_cnt[1] - snap[1]), 64'd0);
        chk("R9", "ch0 latency", 64'(last_done[0] - last_trig[0]), 64'd11);
        chk("R9", "ch2 latency", 64'(last_done[2] - last_trig[2]), 64'd16);
        chk("R9", "ch2 value", 64'(work_of(2)), 64'hC0DE_0002);
        sync_pin = 1'b0;
        settle(2);
        sync_pin = 1'b1;
        settle(25);
        chk("R9", "second edge ch0", 64'(done_cnt[0] - snap[0]), 64'd2);
        chk("R9", "second edge ch2", 64'(done_cnt[2] - snap[2]), 64'd2);
        sync_pin = 1'b0;
        pin_mask = '0;

        // R5: largest delay
        wr(2, 2'd2, 16'hFFFF);
        set_freq(2, 32'h7654_3210);
        hop(3'b100, 1'b1);
        settle(65535 + TRIG_LAT + 3);
        chk("R5", "max delay latency", 64'(last_done[2] - last_trig[2]), 64'd65542);
        chk("R5", "max delay value", 64'(work_of(2)), 64'h7654_3210);

        finish_run();
    end

endmodule